// File: doc/BRIEF.md
# Segment-Page Address Translator with Lookaside Buffer

The block turns a 20-bit logical address into a 20-bit physical address for a memory of 32-bit words. The logical address is split into a 4-bit segment in bits 19:16, an 8-bit page in bits 15:8 and an 8-bit word offset in bits 7:0. The physical address is a 12-bit block number in bits 19:8 followed by the unchanged word offset in bits 7:0.

Every request is first looked up in an eight-entry associative buffer. Each buffer entry maps a (segment, page) pair to a block number and an access-rights code. On a buffer miss the block walks two tables held in internal registers. The segment table yields a page-table base, and the base plus the page number, taken modulo 256, indexes the page table. The page-table entry gives a presence bit, rights and a block number. A successful walk is written into the buffer, and victims are chosen in round-robin order. A missing page or an access that breaks the rights ends the request with a fault code in place of an address.

Software fills both tables through a write port. It has to pulse the flush input after changing a mapping that may already be held in the buffer.

Top module: `segpage_xlate`

## Requirements
- R1: After reset, respValid is 0 and reqReady is 1.
- R2: A translation without a fault returns {block, word}. The block comes from page-table entry (segBase + page) mod 256, where segBase is the segment-table entry of the segment, and the word offset is copied unchanged.
- R3: With segment 6 given base 0x35 and page entries 0x35→0x012, 0x36→0x000, 0x37→0x019, 0x38→0x053 and 0x39→0xA61, logical address 0x6027E gives 0x0197E.
- R4: A request that misses the buffer responds 3 cycles after it is accepted. A fault-free walk is stored in the buffer, so the same request then hits and responds 1 cycle after acceptance.
- R5: A page-table entry with presence bit 0 gives respFault=1, respFaultCode=2'b01 and respPhysAddr=0. A faulting walk is not stored in the buffer, so repeating the request takes 3 cycles again.
- R6: The rights code is 2'b00 read/write, 2'b01 read-only, 2'b10 execute-only and 2'b11 system-only. The access code is 2'b00 read, 2'b01 write and 2'b10 fetch. A write to read-only, a read or write to execute-only, or any access with reqUser=1 to system-only gives respFaultCode=2'b10 and respPhysAddr=0. Every other combination is allowed.
- R7: When a page is absent and the access also breaks its rights, the page fault code 2'b01 is reported.
- R8: The buffer holds 8 entries and replaces them round-robin. After a flush and 9 fault-free walks, the first mapping has been evicted and the third still hits.
- R9: A one-cycle pulse on tlbFlush invalidates every buffer entry, so a request that hit before the pulse misses afterwards.
- R10: reqReady is 0 during the two walk cycles, and reqValid is ignored while reqReady is 0.
- R11: Rewriting a page-table entry does not change a mapping already in the buffer. Hits keep returning the old block until a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translate request strobe |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqLogAddr | input | 20 | Logical address {segment, page, word} |
| reqAccess | input | 2 | 00 read, 01 write, 10 fetch |
| reqUser | input | 1 | 1 for a user-mode access |
| respValid | output | 1 | One-cycle response strobe |
| respPhysAddr | output | 20 | {block, word}, zero on a fault |
| respFault | output | 1 | Response carries a fault |
| respFaultCode | output | 2 | 00 none, 01 page absent, 10 protection |
| tblWrEn | input | 1 | Table write strobe |
| tblSel | input | 1 | 0 segment table, 1 page table |
| tblAddr | input | 8 | Table index (segment uses bits 3:0) |
| tblData | input | 15 | Segment: base in bits 7:0; page: present bit 14, rights 13:12, block 11:0 |
| tlbFlush | input | 1 | Invalidate every buffer entry |

## Verification
A buffer hit is registered at the accepting edge, so its response is due at the first falling edge after acceptance. A walk adds one edge for the segment table and one for the page table, so its response is due at the third falling edge. The bench counts falling edges from acceptance to respValid and compares that count with 1 or 3, and it samples the address and fault code in the same half cycle. For each swept case it flushes first, so the first request has to miss. The expected latency of the repeated request follows from whether the first one faulted.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int SEG_W  = 4;
  localparam int PAGE_W = 8;
  localparam int WORD_W = 8;
  localparam int BLK_W  = 12;
  localparam int TLB_N  = 8;

  localparam logic [1:0] ACC_READ  = 2'b00;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  localparam logic [1:0] RT_RW  = 2'b00;
  localparam logic [1:0] RT_RO  = 2'b01;
  localparam logic [1:0] RT_XO  = 2'b10;
  localparam logic [1:0] RT_SYS = 2'b11;

  localparam logic [1:0] FC_NONE = 2'b00;
  localparam logic [1:0] FC_PAGE = 2'b01;
  localparam logic [1:0] FC_PROT = 2'b10;

  typedef struct packed {
    logic capture;
    logic respHit;
    logic segRd;
    logic pageRd;
  } strobe_t;

  function automatic logic rightsDeny(input logic [1:0] rights,
                                      input logic [1:0] acc,
                                      input logic user);
    case (rights)
      RT_RO:   return acc == ACC_WRITE;
      RT_XO:   return acc != ACC_FETCH;
      RT_SYS:  return user;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    tlbHit,
  output logic    reqReady,
  output strobe_t stb
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEG, ST_PAGE} state_t;
  state_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    reqReady = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.capture = 1'b1;
          if (tlbHit) stb.respHit = 1'b1;
          else        stateNxt    = ST_SEG;
        end
      end
      ST_SEG: begin
        stb.segRd = 1'b1;
        stateNxt  = ST_PAGE;
      end
      ST_PAGE: begin
        stb.pageRd = 1'b1;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/xlate_dpath.sv
module xlate_dpath
  import xlate_pkg::*;
#(
  parameter int SegW  = SEG_W,
  parameter int PageW = PAGE_W,
  parameter int WordW = WORD_W,
  parameter int BlkW  = BLK_W,
  parameter int TlbN  = TLB_N
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      stb,
  input  logic [SegW+PageW+WordW-1:0]  reqLogAddr,
  input  logic [1:0]                   reqAccess,
  input  logic                         reqUser,
  input  logic                         tblWrEn,
  input  logic                         tblSel,
  input  logic [PageW-1:0]             tblAddr,
  input  logic [BlkW+2:0]              tblData,
  input  logic                         tlbFlush,
  output logic                         tlbHit,
  output logic                         respValid,
  output logic [BlkW+WordW-1:0]        respPhysAddr,
  output logic                         respFault,
  output logic [1:0]                   respFaultCode
);
  localparam int SegN  = 1 << SegW;
  localparam int PageN = 1 << PageW;
  localparam int PtrW  = (TlbN > 1) ? $clog2(TlbN) : 1;

  // request fields
  logic [SegW-1:0]  inSeg;
  logic [PageW-1:0] inPage;
  logic [WordW-1:0] inWord;
  assign {inSeg, inPage, inWord} = reqLogAddr;

  // tables
  logic [PageW-1:0] segTable [SegN];
  logic             ptPres   [PageN];
  logic [1:0]       ptRt     [PageN];
  logic [BlkW-1:0]  ptBlk    [PageN];

  always_ff @(posedge clk) begin
    if (tblWrEn && !tblSel) segTable[tblAddr[SegW-1:0]] <= tblData[PageW-1:0];
    if (tblWrEn && tblSel) begin
      ptPres[tblAddr] <= tblData[BlkW+2];
      ptRt[tblAddr]   <= tblData[BlkW+1:BlkW];
      ptBlk[tblAddr]  <= tblData[BlkW-1:0];
    end
  end

  // captured request
  logic [SegW-1:0]  segQ;
  logic [PageW-1:0] pageQ, baseQ;
  logic [WordW-1:0] wordQ;
  logic [1:0]       accQ;
  logic             userQ;

  always_ff @(posedge clk) begin
    if (stb.capture) begin
      segQ  <= inSeg;
      pageQ <= inPage;
      wordQ <= inWord;
      accQ  <= reqAccess;
      userQ <= reqUser;
    end
    if (stb.segRd) baseQ <= segTable[segQ];
  end

  // lookaside buffer
  logic            tlbVld  [TlbN];
  logic [SegW-1:0] tlbSeg  [TlbN];
  logic [PageW-1:0] tlbPage[TlbN];
  logic [BlkW-1:0] tlbBlk  [TlbN];
  logic [1:0]      tlbRt   [TlbN];
  logic [TlbN-1:0] hitVec;
  logic [PtrW-1:0] rrPtr;
  logic            insert;

  logic [PageW-1:0] pteIdx;
  logic             walkPf, walkProt;
  assign pteIdx   = baseQ + pageQ;
  assign walkPf   = !ptPres[pteIdx];
  assign walkProt = rightsDeny(ptRt[pteIdx], accQ, userQ);
  assign insert   = stb.pageRd && !walkPf && !walkProt && !tlbFlush;

  for (genvar e = 0; e < TlbN; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN || tlbFlush) begin
        tlbVld[e] <= 1'b0;
      end else if (insert && rrPtr == PtrW'(e)) begin
        tlbVld[e]  <= 1'b1;
        tlbSeg[e]  <= segQ;
        tlbPage[e] <= pageQ;
        tlbBlk[e]  <= ptBlk[pteIdx];
        tlbRt[e]   <= ptRt[pteIdx];
      end
    end
    assign hitVec[e] = tlbVld[e] && tlbSeg[e] == inSeg && tlbPage[e] == inPage;
  end

  always_ff @(posedge clk) begin
    if (!rstN || tlbFlush)                rrPtr <= '0;
    else if (insert && rrPtr == PtrW'(TlbN - 1)) rrPtr <= '0;
    else if (insert)                      rrPtr <= rrPtr + 1'b1;
  end

  logic [BlkW-1:0] hitBlk;
  logic [1:0]      hitRt;
  always_comb begin
    hitBlk = '0;
    hitRt  = '0;
    for (int e = 0; e < TlbN; e++) begin
      if (hitVec[e]) begin
        hitBlk = hitBlk | tlbBlk[e];
        hitRt  = hitRt | tlbRt[e];
      end
    end
  end
  assign tlbHit = |hitVec;

  logic hitProt;
  assign hitProt = rightsDeny(hitRt, reqAccess, reqUser);

  // response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid     <= 1'b0;
      respPhysAddr  <= '0;
      respFault     <= 1'b0;
      respFaultCode <= FC_NONE;
    end else begin
      respValid <= stb.respHit || stb.pageRd;
      if (stb.respHit) begin
        respFault     <= hitProt;
        respFaultCode <= hitProt ? FC_PROT : FC_NONE;
        respPhysAddr  <= hitProt ? '0 : {hitBlk, inWord};
      end else if (stb.pageRd) begin
        respFault     <= walkPf || walkProt;
        respFaultCode <= walkPf ? FC_PAGE : (walkProt ? FC_PROT : FC_NONE);
        respPhysAddr  <= (walkPf || walkProt) ? '0 : {ptBlk[pteIdx], wordQ};
      end
    end
  end
endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
  import xlate_pkg::*;
#(
  parameter int SegW  = SEG_W,
  parameter int PageW = PAGE_W,
  parameter int WordW = WORD_W,
  parameter int BlkW  = BLK_W,
  parameter int TlbN  = TLB_N
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [SegW+PageW+WordW-1:0] reqLogAddr,
  input  logic [1:0]                  reqAccess,
  input  logic                        reqUser,
  output logic                        respValid,
  output logic [BlkW+WordW-1:0]       respPhysAddr,
  output logic                        respFault,
  output logic [1:0]                  respFaultCode,
  input  logic                        tblWrEn,
  input  logic                        tblSel,
  input  logic [PageW-1:0]            tblAddr,
  input  logic [BlkW+2:0]             tblData,
  input  logic                        tlbFlush
);
  strobe_t stb;
  logic    tlbHit;

  xlate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .tlbHit   (tlbHit),
    .reqReady (reqReady),
    .stb      (stb)
  );

  xlate_dpath #(
    .SegW(SegW), .PageW(PageW), .WordW(WordW), .BlkW(BlkW), .TlbN(TlbN)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .reqLogAddr    (reqLogAddr),
    .reqAccess     (reqAccess),
    .reqUser       (reqUser),
    .tblWrEn       (tblWrEn),
    .tblSel        (tblSel),
    .tblAddr       (tblAddr),
    .tblData       (tblData),
    .tlbFlush      (tlbFlush),
    .tlbHit        (tlbHit),
    .respValid     (respValid),
    .respPhysAddr  (respPhysAddr),
    .respFault     (respFault),
    .respFaultCode (respFaultCode)
  );
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
  parameter int WordW = 8,
  parameter int PaW   = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [WordW-1:0] reqWord,
  input logic             respValid,
  input logic [PaW-1:0]   respPhysAddr,
  input logic             respFault,
  input logic [1:0]       respFaultCode
);
  logic [WordW-1:0] lastWord;
  always_ff @(posedge clk) begin
    if (!rstN) lastWord <= '0;
    else if (reqValid && reqReady) lastWord <= reqWord;
  end

  p_wordpass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFault) |-> respPhysAddr[WordW-1:0] == lastWord);

  p_faultaddr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault) |-> respPhysAddr == '0);

  p_faultcode_r6: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (respFault == (respFaultCode != 2'b00)));

  p_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |-> !respValid);

  p_accept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (respValid || !reqReady));
endmodule

bind segpage_xlate xlate_chk #(.WordW(WordW), .PaW(BlkW + WordW)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .reqReady      (reqReady),
  .reqWord       (reqLogAddr[WordW-1:0]),
  .respValid     (respValid),
  .respPhysAddr  (respPhysAddr),
  .respFault     (respFault),
  .respFaultCode (respFaultCode)
);

// File: tb/tb_segpage_xlate.sv
`timescale 1ns/1ps
module tb_segpage_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [19:0] reqLogAddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqUser = 1'b0;
  logic        respValid;
  logic [19:0] respPhysAddr;
  logic        respFault;
  logic [1:0]  respFaultCode;
  logic        tblWrEn = 1'b0;
  logic        tblSel = 1'b0;
  logic [7:0]  tblAddr = '0;
  logic [14:0] tblData = '0;
  logic        tlbFlush = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  segpage_xlate dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqLogAddr(reqLogAddr), .reqAccess(reqAccess), .reqUser(reqUser),
    .respValid(respValid), .respPhysAddr(respPhysAddr), .respFault(respFault),
    .respFaultCode(respFaultCode), .tblWrEn(tblWrEn), .tblSel(tblSel),
    .tblAddr(tblAddr), .tblData(tblData), .tlbFlush(tlbFlush)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // sweep table contents
  function automatic int segBase(input int s);
    return (s * 16 + 3) & 8'hFF;
  endfunction
  function automatic bit ptPresent(input int i); return (i % 11) != 4; endfunction
  function automatic int ptRights(input int i); return (i >> 2) & 3; endfunction
  function automatic int ptBlock(input int i); return (i * 37 + 5) & 12'hFFF; endfunction

  function automatic int expCode(input int idx, input int acc, input bit user);
    int rt;
    if (!ptPresent(idx)) return 1;
    rt = ptRights(idx);
    if (rt == 1 && acc == 1) return 2;
    if (rt == 2 && acc != 2) return 2;
    if (rt == 3 && user) return 2;
    return 0;
  endfunction

  task automatic loadSeg(input int s, input int base);
    @(negedge clk);
    tblWrEn = 1'b1; tblSel = 1'b0; tblAddr = 8'(s); tblData = 15'(base);
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  task automatic loadPage(input int i, input bit pres, input int rt, input int blk);
    @(negedge clk);
    tblWrEn = 1'b1; tblSel = 1'b1; tblAddr = 8'(i);
    tblData = {pres, 2'(rt), 12'(blk)};
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    tlbFlush = 1'b1;
    @(negedge clk);
    tlbFlush = 1'b0;
  endtask

  task automatic xlate(input int la, input int acc, input bit user,
                       output int lat, output int pa, output int code);
    @(negedge clk);
    reqValid = 1'b1; reqLogAddr = 20'(la); reqAccess = 2'(acc); reqUser = user;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!respValid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    pa = int'(respPhysAddr);
    code = int'(respFaultCode);
  endtask

  task automatic loadSweepTables();
    for (int s = 0; s < 16; s++) loadSeg(s, segBase(s));
    for (int i = 0; i < 256; i++) loadPage(i, ptPresent(i), ptRights(i), ptBlock(i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat, pa, code, idx, expPa, ec;
    int rrPages[9];
    int n;

    repeat (3) @(negedge clk);
    chk(respValid == 1'b0, "R1", "respValid in reset", respValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(respValid == 1'b0, "R1", "respValid after reset", respValid, 0);
    chk(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);

    // R3 worked example
    loadSeg(6, 8'h35);
    loadPage(8'h35, 1, 0, 12'h012);
    loadPage(8'h36, 1, 0, 12'h000);
    loadPage(8'h37, 1, 0, 12'h019);
    loadPage(8'h38, 1, 0, 12'h053);
    loadPage(8'h39, 1, 0, 12'hA61);
    flush();
    xlate(20'h6027E, 0, 0, lat, pa, code);
    chk(pa == 20'h0197E, "R3", "example address", pa, 20'h0197E);
    chk(lat == 3, "R4", "miss latency", lat, 3);
    xlate(20'h6027E, 0, 0, lat, pa, code);
    chk(lat == 1, "R4", "hit latency", lat, 1);
    chk(pa == 20'h0197E, "R3", "example address on hit", pa, 20'h0197E);
    xlate(20'h604C3, 0, 0, lat, pa, code);
    chk(pa == 20'hA61C3, "R3", "page 4 address", pa, 20'hA61C3);

    // R9 flush
    flush();
    xlate(20'h6027E, 0, 0, lat, pa, code);
    chk(lat == 3, "R9", "latency after flush", lat, 3);

    // R10 busy during walk
    flush();
    @(negedge clk);
    reqValid = 1'b1; reqLogAddr = 20'h60311; reqAccess = 2'd0; reqUser = 1'b0;
    @(negedge clk);
    reqLogAddr = 20'h60455;
    chk(reqReady == 1'b0, "R10", "ready in segment cycle", reqReady, 0);
    @(negedge clk);
    chk(reqReady == 1'b0, "R10", "ready in page cycle", reqReady, 0);
    reqValid = 1'b0;
    @(negedge clk);
    chk(respValid == 1'b1, "R10", "walk response", respValid, 1);
    chk(respPhysAddr == 20'h05311, "R10", "first request served", int'(respPhysAddr), 20'h05311);
    @(negedge clk);
    chk(respValid == 1'b0, "R10", "no response to ignored request", respValid, 0);

    // sweep
    loadSweepTables();
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 5; k++) begin
        int p;
        p = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 8'h80 : (k == 3) ? 8'hFF : ((s * 17) & 8'hFF);
        idx = (segBase(s) + p) & 8'hFF;
        for (int acc = 0; acc < 3; acc++) begin
          for (int u = 0; u < 2; u++) begin
            int la;
            la = (s << 16) | (p << 8) | ((s * 29 + p + acc) & 8'hFF);
            ec = expCode(idx, acc, u[0]);
            expPa = (ec != 0) ? 0 : ((ptBlock(idx) << 8) | (la & 8'hFF));
            flush();
            xlate(la, acc, u[0], lat, pa, code);
            chk(lat == 3, "R4", "sweep miss latency", lat, 3);
            chk(pa == expPa, "R2", "sweep address", pa, expPa);
            chk(code == ec, (ec == 1) ? "R5" : "R6", "sweep fault code", code, ec);
            xlate(la, acc, u[0], lat, pa, code);
            chk(lat == ((ec != 0) ? 3 : 1), (ec != 0) ? "R5" : "R4", "repeat latency",
                lat, (ec != 0) ? 3 : 1);
            chk(pa == expPa, "R2", "repeat address", pa, expPa);
            chk(code == ec, "R6", "repeat fault code", code, ec);
          end
        end
      end
    end

    // R7 page fault wins: segment 0 page 1 -> index 4 (absent, read-only), write
    flush();
    xlate(20'h00100, 1, 1, lat, pa, code);
    chk(code == 1, "R7", "absent and write to read-only", code, 1);
    chk(pa == 0, "R5", "no address on fault", pa, 0);

    // R8 round robin: segment 1, fetch in supervisor mode never breaks rights
    n = 0;
    for (int p = 0; p < 64 && n < 9; p++) begin
      if (ptPresent((segBase(1) + p) & 8'hFF)) begin
        rrPages[n] = p;
        n++;
      end
    end
    flush();
    for (int j = 0; j < 9; j++) begin
      xlate((1 << 16) | (rrPages[j] << 8), 2, 0, lat, pa, code);
      chk(lat == 3, "R8", "fill miss", lat, 3);
    end
    xlate((1 << 16) | (rrPages[2] << 8), 2, 0, lat, pa, code);
    chk(lat == 1, "R8", "third mapping kept", lat, 1);
    xlate((1 << 16) | (rrPages[0] << 8), 2, 0, lat, pa, code);
    chk(lat == 3, "R8", "first mapping evicted", lat, 3);

    // R11 stale mapping until flush
    idx = (segBase(1) + rrPages[0]) & 8'hFF;
    xlate((1 << 16) | (rrPages[0] << 8) | 8'h21, 2, 0, lat, pa, code);
    chk(lat == 1, "R11", "hit before rewrite", lat, 1);
    loadPage(idx, 1, 0, 12'h7AB);
    xlate((1 << 16) | (rrPages[0] << 8) | 8'h21, 2, 0, lat, pa, code);
    chk(lat == 1, "R11", "hit after rewrite", lat, 1);
    chk(pa == ((ptBlock(idx) << 8) | 8'h21), "R11", "old block kept", pa,
        (ptBlock(idx) << 8) | 8'h21);
    flush();
    xlate((1 << 16) | (rrPages[0] << 8) | 8'h21, 2, 0, lat, pa, code);
    chk(pa == 20'h7AB21, "R11", "new block after flush", pa, 20'h7AB21);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule